// File: doc/BRIEF.md
# Serial Programming-Mode Entry Sequencer

This block brings a target device into its serial programming mode. It drives the target's reset line and acts as a bit-level SPI master on SCK, MOSI and MISO. A one-cycle `start` pulse begins the sequence. The block samples an 8-bit device-family code at that moment, and the code decides two things: the polarity of the reset sequence, and whether the target's echo is checked. Every wait between phases is counted in system clocks and set by a parameter.

In the sequence, the reset line first moves to its entry levels with a hold delay and a settle delay. The block then shifts out the two-byte enable instruction, 0xAC followed by 0x53. For one range of codes it reads the third byte back and looks for the echo 0x53. When the echo is missing, it resynchronises with one extra SCK pulse and sends the enable instruction again, for up to `MAX_TRIES` reads. It then sends a trailing zero byte when the code requires one, waits a final delay, and pulses `done`. If no read matched, `sync_fail` rises and `done` still follows.

There is no data stream at this block's edge: `start`, `dev_code`, `done` and `sync_fail` are plain control and status pins, so no valid/ready handshake applies. The block applies no back-pressure: a `start` that arrives during a sequence is dropped.

Top module: `isp_entry_seq`

## Requirements
- R1: After reset, and while idle, `tgt_reset` is 1 and `sck`, `mosi`, `done` and `sync_fail` are 0.
- R2: On the clock edge that samples `start`, `tgt_reset` takes its first level: 0 for code 0x86, 1 for every other code. It holds that level for RESET_DLY+1 cycles and then switches to the opposite level, which it keeps until the next `start`.
- R3: After the reset transition, `sck` stays low for SETTLE_DLY+1 cycles before the first bit. `sck` is also low during every other delay.
- R4: Bytes are shifted MSB first. Each bit drives `sck` high for SCK_HI cycles, then low for SCK_LO cycles. `mosi` changes only on the edge at which `sck` rises. Every transfer ends with one extra low cycle, and between transfers `mosi` keeps its last bit.
- R5: The enable instruction is the byte 0xAC followed by the byte 0x53.
- R6: For codes from 0x20 to 0x7F inclusive, the third byte is a read with `mosi` held at 0. `miso` is sampled MSB first on each edge at which `sck` rises. A read value of 0x53 ends the search.
- R7: After a read that does not match, the block sends 0x00, then a single SCK pulse with `mosi` at 0, then 0xAC and 0x53, and then reads again.
- R8: After MAX_TRIES reads with no match, no further resynchronisation is sent. `sync_fail` becomes 1 and stays 1 until the next `start`. The sequence still completes.
- R9: For codes outside 0x20 to 0x7F, the third byte is written as 0x00 and `miso` has no effect.
- R10: A final byte 0x00 follows the third byte unless the code is 0x86.
- R11: After the last byte, a delay of FINAL_DLY+1 cycles follows. Then `done` is 1 for exactly one cycle, and `tgt_reset` keeps its second level.
- R12: A `start` pulse during a running sequence is ignored, and `dev_code` is only sampled on the accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins the entry sequence |
| dev_code | input | 8 | Device-family code, sampled with `start` |
| miso | input | 1 | Serial data from the target |
| tgt_reset | output | 1 | Reset line driven to the target |
| sck | output | 1 | Serial clock to the target |
| mosi | output | 1 | Serial data to the target |
| done | output | 1 | One-cycle pulse when the sequence has finished |
| sync_fail | output | 1 | Set when every echo check failed; cleared by the next `start` |

## Verification
The assertions rely on all delay and phase-length parameters being at least 1. With that in place, the sub-engines' handshakes give a `go` only to an idle engine. The assertions make no assumption about `miso` or about when `start` arrives, so the bench changes `miso` freely on falling clock edges and drives a `start` with a new code in the middle of a run. The stimulus covers both edges of the echo-check range (0x1F, 0x20, 0x7F, 0x80). It also covers the reversed-polarity code, an echo that matches at once, one that matches after two resynchronisations, and one that never matches.

// File: rtl/isp_entry_pkg.sv
package isp_entry_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_HOLD,
    ST_SETTLE,
    ST_EN1,
    ST_EN2,
    ST_READ,
    ST_RS_ZERO,
    ST_RS_PULSE,
    ST_RS_EN1,
    ST_RS_EN2,
    ST_THIRD,
    ST_FOURTH,
    ST_FINAL
  } seq_state_t;

  localparam logic [7:0] EN_OP      = 8'hAC;
  localparam logic [7:0] EN_KEY     = 8'h53;
  localparam logic [7:0] FAM51_CODE = 8'h86;
  localparam logic [7:0] SYNC_LO    = 8'h20;
  localparam logic [7:0] SYNC_HI    = 8'h7F;

endpackage

// File: rtl/isp_delay_timer.sv
module isp_delay_timer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] len,
  output logic          fin,
  output logic          running
);

  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        cnt     <= len;
        running <= 1'b1;
      end else if (running) begin
        if (cnt == DW'(1)) begin
          running <= 1'b0;
          fin     <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // Back-to-back expiry is impossible: a reload needs at least two cycles.
  assert_fin_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);

endmodule

// File: rtl/isp_bit_shifter.sv
module isp_bit_shifter #(
  parameter int SCK_HI = 6,
  parameter int SCK_LO = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       pulse_only,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       fin
);

  localparam int PMAX = (SCK_HI > SCK_LO) ? SCK_HI : SCK_LO;
  localparam int CW   = $clog2(PMAX) + 1;

  typedef enum logic [1:0] {SH_IDLE, SH_HI, SH_LO} sh_state_t;

  sh_state_t     st;
  logic [CW-1:0] cnt;
  logic [2:0]    bits;
  logic [7:0]    shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SH_IDLE;
      cnt     <= '0;
      bits    <= '0;
      shreg   <= '0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      rx_byte <= '0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        SH_IDLE: begin
          if (go) begin
            st      <= SH_HI;
            cnt     <= CW'(SCK_HI - 1);
            sck     <= 1'b1;
            rx_byte <= {rx_byte[6:0], miso};
            if (pulse_only) begin
              mosi  <= 1'b0;
              shreg <= '0;
              bits  <= 3'd0;
            end else begin
              mosi  <= tx_byte[7];
              shreg <= {tx_byte[6:0], 1'b0};
              bits  <= 3'd7;
            end
          end
        end
        SH_HI: begin
          if (cnt == '0) begin
            st  <= SH_LO;
            cnt <= CW'(SCK_LO - 1);
            sck <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SH_LO: begin
          if (cnt == '0) begin
            if (bits == 3'd0) begin
              st  <= SH_IDLE;
              fin <= 1'b1;
            end else begin
              st      <= SH_HI;
              cnt     <= CW'(SCK_HI - 1);
              sck     <= 1'b1;
              mosi    <= shreg[7];
              shreg   <= {shreg[6:0], 1'b0};
              bits    <= bits - 3'd1;
              rx_byte <= {rx_byte[6:0], miso};
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end

  // Length of the current high phase, kept for checking only.
  int hi_run;
  always_ff @(posedge clk) begin
    if (!rst_n) hi_run <= 0;
    else        hi_run <= sck ? hi_run + 1 : 0;
  end

  assert_sck_high_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> (hi_run == SCK_HI));

  assert_go_only_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (st == SH_IDLE));

endmodule

// File: rtl/isp_entry_seq.sv
module isp_entry_seq
  import isp_entry_pkg::*;
#(
  parameter int SCK_HI     = 6,
  parameter int SCK_LO     = 2,
  parameter int RESET_DLY  = 40,
  parameter int SETTLE_DLY = 30,
  parameter int FINAL_DLY  = 12,
  parameter int MAX_TRIES  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] dev_code,
  input  logic       miso,
  output logic       tgt_reset,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic       sync_fail
);

  localparam int MAXD01 = (RESET_DLY > SETTLE_DLY) ? RESET_DLY : SETTLE_DLY;
  localparam int MAXD   = (MAXD01 > FINAL_DLY) ? MAXD01 : FINAL_DLY;
  localparam int DW     = $clog2(MAXD + 1) + 1;
  localparam int TW     = $clog2(MAX_TRIES + 1);

  seq_state_t    state, nxt;
  logic [7:0]    code_q;
  logic          rst_q, done_q, fail_q;
  logic [TW-1:0] tries_q;

  logic          t_go, t_fin, t_run;
  logic [DW-1:0] t_len;
  logic          s_go, s_pulse, s_fin;
  logic [7:0]    s_byte, rx_byte;

  logic in_rng, is51, echo_ok, last_try;

  assign in_rng   = (code_q >= SYNC_LO) && (code_q <= SYNC_HI);
  assign is51     = (code_q == FAM51_CODE);
  assign echo_ok  = (rx_byte == EN_KEY);
  assign last_try = (tries_q == TW'(MAX_TRIES - 1));

  isp_delay_timer #(.DW(DW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (t_go),
    .len     (t_len),
    .fin     (t_fin),
    .running (t_run)
  );

  isp_bit_shifter #(.SCK_HI(SCK_HI), .SCK_LO(SCK_LO)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (s_go),
    .pulse_only (s_pulse),
    .tx_byte    (s_byte),
    .miso       (miso),
    .sck        (sck),
    .mosi       (mosi),
    .rx_byte    (rx_byte),
    .fin        (s_fin)
  );

  always_comb begin
    nxt     = state;
    t_go    = 1'b0;
    t_len   = '0;
    s_go    = 1'b0;
    s_pulse = 1'b0;
    s_byte  = 8'h00;
    case (state)
      ST_IDLE: if (start) begin
        t_go = 1'b1; t_len = DW'(RESET_DLY); nxt = ST_RST_HOLD;
      end
      ST_RST_HOLD: if (t_fin) begin
        t_go = 1'b1; t_len = DW'(SETTLE_DLY); nxt = ST_SETTLE;
      end
      ST_SETTLE: if (t_fin) begin
        s_go = 1'b1; s_byte = EN_OP; nxt = ST_EN1;
      end
      ST_EN1: if (s_fin) begin
        s_go = 1'b1; s_byte = EN_KEY; nxt = ST_EN2;
      end
      ST_EN2: if (s_fin) begin
        s_go = 1'b1; nxt = in_rng ? ST_READ : ST_THIRD;
      end
      ST_READ: if (s_fin) begin
        if (echo_ok || last_try) begin
          s_go = 1'b1; nxt = ST_FOURTH;
        end else begin
          s_go = 1'b1; nxt = ST_RS_ZERO;
        end
      end
      ST_RS_ZERO: if (s_fin) begin
        s_go = 1'b1; s_pulse = 1'b1; nxt = ST_RS_PULSE;
      end
      ST_RS_PULSE: if (s_fin) begin
        s_go = 1'b1; s_byte = EN_OP; nxt = ST_RS_EN1;
      end
      ST_RS_EN1: if (s_fin) begin
        s_go = 1'b1; s_byte = EN_KEY; nxt = ST_RS_EN2;
      end
      ST_RS_EN2: if (s_fin) begin
        s_go = 1'b1; nxt = ST_READ;
      end
      ST_THIRD: if (s_fin) begin
        if (is51) begin
          t_go = 1'b1; t_len = DW'(FINAL_DLY); nxt = ST_FINAL;
        end else begin
          s_go = 1'b1; nxt = ST_FOURTH;
        end
      end
      ST_FOURTH: if (s_fin) begin
        t_go = 1'b1; t_len = DW'(FINAL_DLY); nxt = ST_FINAL;
      end
      ST_FINAL: if (t_fin) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      code_q  <= '0;
      rst_q   <= 1'b1;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      tries_q <= '0;
    end else begin
      state  <= nxt;
      done_q <= (state == ST_FINAL) && t_fin;
      if (state == ST_IDLE && start) begin
        code_q  <= dev_code;
        rst_q   <= (dev_code != FAM51_CODE);
        fail_q  <= 1'b0;
        tries_q <= '0;
      end
      if (state == ST_RST_HOLD && t_fin) rst_q <= ~rst_q;
      if (state == ST_READ && s_fin && !echo_ok) begin
        if (last_try) fail_q  <= 1'b1;
        else          tries_q <= tries_q + 1'b1;
      end
    end
  end

  assign tgt_reset = rst_q;
  assign done      = done_q;
  assign sync_fail = fail_q;

  assert_reset_line_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && state != ST_RST_HOLD) |=> $stable(tgt_reset));

  assert_sck_quiet_in_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    t_run |-> !sck);

  assert_tries_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q < TW'(MAX_TRIES));

  assert_no_read_outside_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_rng |-> (state != ST_READ));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/tb_isp_entry_seq.sv
`timescale 1ns/1ps
module tb_isp_entry_seq;

  localparam int HI  = 6;
  localparam int LO  = 2;
  localparam int P   = HI + LO;
  localparam int RST = 40;
  localparam int SET = 30;
  localparam int FIN = 12;
  localparam int MAX = 32;
  localparam int WD  = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] dev_code = 8'h00;
  logic miso = 1'b0;
  logic tgt_reset, sck, mosi, done, sync_fail;

  always #5 clk = ~clk;

  isp_entry_seq #(
    .SCK_HI(HI), .SCK_LO(LO), .RESET_DLY(RST), .SETTLE_DLY(SET),
    .FINAL_DLY(FIN), .MAX_TRIES(MAX)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_code(dev_code), .miso(miso),
    .tgt_reset(tgt_reset), .sck(sck), .mosi(mosi), .done(done), .sync_fail(sync_fail)
  );

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int tickno = 0;
  int inj_at = -1;
  logic [7:0] inj_code = 8'h00;
  logic exp_rst = 1'b1;
  logic exp_mosi = 1'b0;
  logic exp_fail = 1'b0;
  logic [7:0] rsp [MAX];

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD) begin
      nfail++;
      $display("FAIL watchdog: got %0d cycles, expected at most %0d", cyc, WD);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  // One reference cycle: compare every output, then set MISO for the next edge.
  task automatic tick(input logic esck, input logic edone, input string tag, input logic nm);
    @(negedge clk);
    nchk++;
    if (tgt_reset !== exp_rst || sck !== esck || mosi !== exp_mosi ||
        done !== edone || sync_fail !== exp_fail) begin
      nfail++;
      $display("FAIL %s at %0t: rst,sck,mosi,done,fail got %b%b%b%b%b expected %b%b%b%b%b",
               tag, $time, tgt_reset, sck, mosi, done, sync_fail,
               exp_rst, esck, exp_mosi, edone, exp_fail);
    end
    miso = nm;
    tickno++;
    if (tickno == inj_at) begin
      start = 1'b1;
      dev_code = inj_code;
    end else begin
      start = 1'b0;
    end
  endtask

  task automatic seg_delay(input int len, input string tag, input logic nf);
    for (int r = 1; r <= len + 1; r++)
      tick(1'b0, 1'b0, tag, (r == len + 1) ? nf : ~miso);
  endtask

  task automatic seg_pulse(input string tag, input logic nf);
    for (int r = 1; r <= P + 1; r++) begin
      if (r <= P) exp_mosi = 1'b0;
      tick(r <= HI, 1'b0, tag, (r == P + 1) ? nf : ~miso);
    end
  endtask

  task automatic seg_byte(input logic [7:0] b, input bit rd, input logic [7:0] resp,
                          input logic nf, input string tag);
    for (int r = 1; r <= 8 * P + 1; r++) begin
      logic esck;
      logic nm;
      int bi;
      esck = 1'b0;
      if (r <= 8 * P) begin
        bi = (r - 1) / P;
        esck = ((r - 1) % P) < HI;
        exp_mosi = rd ? 1'b0 : b[7 - bi];
      end
      if (r == 8 * P + 1)                       nm = nf;
      else if (rd && (r % P == 0) && r < 8 * P) nm = resp[7 - r / P];
      else if (rd)                              nm = miso;
      else                                      nm = ~miso;
      tick(esck, 1'b0, tag, nm);
    end
  endtask

  task automatic run_seq(input logic [7:0] code, input int inj, input logic [7:0] icode);
    logic first;
    logic inr;
    inj_at = inj;
    inj_code = icode;
    dev_code = code;
    start = 1'b1;
    tickno = 0;
    exp_fail = 1'b0;
    first = (code != 8'h86);
    inr = (code >= 8'h20) && (code <= 8'h7F);
    exp_rst = first;
    seg_delay(RST, "R2", 1'b0);
    exp_rst = ~first;
    seg_delay(SET, "R3", 1'b0);
    seg_byte(8'hAC, 1'b0, 8'h00, 1'b0, "R5");
    seg_byte(8'h53, 1'b0, 8'h00, inr ? rsp[0][7] : 1'b0, "R5");
    if (inr) begin
      for (int k = 0; k < MAX; k++) begin
        seg_byte(8'h00, 1'b1, rsp[k], 1'b0, (k == MAX - 1) ? "R8" : "R6");
        if (rsp[k] == 8'h53) break;
        if (k == MAX - 1) begin
          exp_fail = 1'b1;
          break;
        end
        seg_byte(8'h00, 1'b0, 8'h00, 1'b0, "R7");
        seg_pulse("R7", 1'b0);
        seg_byte(8'hAC, 1'b0, 8'h00, 1'b0, "R7");
        seg_byte(8'h53, 1'b0, 8'h00, rsp[k + 1][7], "R7");
      end
    end else begin
      seg_byte(8'h00, 1'b0, 8'h00, 1'b0, "R9");
    end
    if (code != 8'h86) seg_byte(8'h00, 1'b0, 8'h00, 1'b0, "R10");
    seg_delay(FIN, "R11", 1'b0);
    tick(1'b0, 1'b1, "R11", ~miso);
    inj_at = -1;
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, "R11", ~miso);
  endtask

  initial begin
    // R1: reset and idle state
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, "R1", 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, "R1", ~miso);

    // R9 lower edge: 0x1F is outside the echo range, MISO toggles and is ignored
    run_seq(8'h1F, -1, 8'h00);

    // R2 reversed polarity, R10 no final byte for 0x86
    run_seq(8'h86, -1, 8'h00);

    // R6 lower edge: 0x20 matches on the first read
    rsp[0] = 8'h53;
    run_seq(8'h20, -1, 8'h00);

    // R7 two resynchronisations; R12 start with a new code mid-run is ignored
    rsp[0] = 8'h00;
    rsp[1] = 8'hA5;
    rsp[2] = 8'h53;
    run_seq(8'h38, 150, 8'h86);

    // R8 upper edge 0x7F: echo never matches, sync_fail set, still done
    for (int i = 0; i < MAX; i++) rsp[i] = 8'h52;
    run_seq(8'h7F, -1, 8'h00);

    // R8 sync_fail cleared by next start; R9 upper edge 0x80 is outside the range
    run_seq(8'h80, -1, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule